// File: doc/BRIEF.md
# Transmit Gain Index Compensation Pipeline

This block turns a desired transmit power for one radio chain into the gain-table index to program. It checks the input limits and replaces values that are out of range. It then caps the target power, first by the regulatory limit and then by the saturation limit less a backoff that depends on the rate. Next it offsets the factory gain index by several terms in a fixed order: the power difference, a temperature correction whose slope depends on the band, a voltage correction that uses different rules above and below the factory code, a MIMO balancing term chosen by channel group, and an extra offset for CCK rates that depends on the hardware revision. Last it clamps the index to the table range of the band.

All power, limit and index values are signed and count in half-dB steps, so one unit of power equals one index step. A higher index means lower gain. One request enters with `in_valid`. The result appears two clock cycles later with `out_valid`, and a new request may enter on every cycle.

Top module: `txgain_comp`

## Requirements
- R1: The target power is the smaller of the desired power and the regulatory limit. When `mimo` is 1, the limit is 6 lower before the comparison.
- R2: The target is then capped at the saturation limit minus a backoff. The `rate_sel` code sets the backoff: 0 = CCK gives 10, 1 = OFDM 6–36 Mb/s gives 10, 2 = 48 Mb/s gives 15, 3 = 54 Mb/s gives 17, 4 = 60 Mb/s gives 20, and codes 5–7 give 10. The MIMO reduction does not apply to this cap.
- R3: A regulatory limit outside 0..34 is replaced by 34. A saturation limit outside 20..50 is replaced by 38.
- R4: The index starts at `fac_idx` + (`fac_pwr` − target).
- R5: Channel numbers 1–20 are 2.4 GHz and all others are 5 GHz. With ΔT = `cur_temp` − `fac_temp`, the index falls by 2·ΔT/7 on 2.4 GHz, by 2·ΔT/9 on channels up to 43, and by 2·ΔT/8 on channels 44 and above. Each quotient is truncated toward zero.
- R6: If `cur_volt` < `fac_volt`, the index rises by (`fac_volt` − `cur_volt`)/7. If `cur_volt` > `fac_volt`, it falls by 2·(`cur_volt` − `fac_volt`)/7. Both quotients truncate. A correction whose magnitude exceeds 2 becomes 0.
- R7: When `mimo` is 1, the index gains the signed byte `att_tab[8g+7:8g]`. The group g is 4 for 2.4 GHz, 0 for channels up to 43, 1 for 44–70, 2 for 71–124, and 3 above 124.
- R8: When `rate_sel` is 0 (CCK), the index gains 9 if `hw_rev` is 1, 5 if `hw_rev` is 2, and 0 otherwise.
- R9: The final index is clamped to the range [0, IDX_MAX] on 2.4 GHz and [−9, IDX_MAX] on 5 GHz.
- R10: `out_valid` rises exactly two cycles after each `in_valid` cycle. Back-to-back requests give back-to-back results.
- R11: While reset is held, `out_valid`, `out_idx` and `out_pwr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| want_pwr | input | PW | Desired power, signed half-dB |
| reg_lim | input | PW | Regulatory limit, signed half-dB |
| sat_lim | input | PW | Saturation limit, signed half-dB |
| rate_sel | input | 3 | Rate class code |
| mimo | input | 1 | Two-transmitter rate |
| chan | input | 8 | Channel number |
| fac_idx | input | PW | Interpolated factory gain index |
| fac_pwr | input | PW | Interpolated factory power, half-dB |
| fac_temp | input | TW | Factory temperature, signed degrees |
| cur_temp | input | TW | Current temperature, signed degrees |
| fac_volt | input | VW | Factory voltage code |
| cur_volt | input | VW | Current voltage code |
| att_tab | input | 5*PW | Five signed attenuation bytes, group 0 in the low byte |
| hw_rev | input | 2 | Hardware revision field |
| out_valid | output | 1 | Result strobe |
| out_idx | output | PW | Final gain-table index, signed |
| out_pwr | output | PW | Final target power, signed half-dB |

## Verification
The power caps in the assertions assume the desired power fits the signed input width. They also assume the limit inputs go through the substitution step, so the checked target never exceeds 34 and is never above 40 past saturation. The latency properties assume `in_valid` is held low during reset and driven only between clock edges. The stimulus respects this by changing inputs on the falling edge. Every vector keeps temperature and voltage differences small enough that the 16-bit internal sums cannot wrap, so the range assertions on the clamped index stay meaningful.

// File: rtl/txgain_comp.sv
module txgain_comp #(
  parameter int PW      = 8,
  parameter int TW      = 10,
  parameter int VW      = 8,
  parameter int IDX_MAX = 107
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [PW-1:0] want_pwr,
  input  logic signed [PW-1:0] reg_lim,
  input  logic signed [PW-1:0] sat_lim,
  input  logic [2:0]           rate_sel,
  input  logic                 mimo,
  input  logic [7:0]           chan,
  input  logic signed [PW-1:0] fac_idx,
  input  logic signed [PW-1:0] fac_pwr,
  input  logic signed [TW-1:0] fac_temp,
  input  logic signed [TW-1:0] cur_temp,
  input  logic [VW-1:0]        fac_volt,
  input  logic [VW-1:0]        cur_volt,
  input  logic [5*PW-1:0]      att_tab,
  input  logic [1:0]           hw_rev,
  output logic                 out_valid,
  output logic signed [PW-1:0] out_idx,
  output logic signed [PW-1:0] out_pwr
);
  localparam int IW = 16;

  logic signed [IW-1:0] reg_ok, sat_ok, reg_eff, sat_eff, bo, tgt;
  logic signed [IW-1:0] dt2, th, vdiff, vr, att, cck, base, adj;
  logic [2:0] grp;
  logic band24;

  assign band24 = (chan <= 8'd20);

  always_comb begin
    reg_ok = (reg_lim < 0 || reg_lim > 34) ? IW'(34) : IW'(reg_lim);
    sat_ok = (sat_lim < 20 || sat_lim > 50) ? IW'(38) : IW'(sat_lim);
    case (rate_sel)
      3'd2:    bo = IW'(15);
      3'd3:    bo = IW'(17);
      3'd4:    bo = IW'(20);
      default: bo = IW'(10);
    endcase
    reg_eff = reg_ok - (mimo ? IW'(6) : IW'(0));
    sat_eff = sat_ok - bo;
    tgt = (IW'(want_pwr) < reg_eff) ? IW'(want_pwr) : reg_eff;
    tgt = (tgt < sat_eff) ? tgt : sat_eff;
  end

  always_comb begin
    dt2 = (IW'(cur_temp) - IW'(fac_temp)) <<< 1;
    if (band24)               th = dt2 / IW'(7);
    else if (chan <= 8'd43)   th = dt2 / IW'(9);
    else                      th = dt2 / IW'(8);
  end

  always_comb begin
    vdiff = '0;
    vr    = '0;
    if (cur_volt < fac_volt) begin
      vdiff = IW'(fac_volt) - IW'(cur_volt);
      vr    = vdiff / IW'(7);
    end else if (cur_volt > fac_volt) begin
      vdiff = IW'(cur_volt) - IW'(fac_volt);
      vr    = -((vdiff + vdiff) / IW'(7));
    end
    if (vr > IW'(2) || vr < -IW'(2)) vr = '0;
  end

  always_comb begin
    if (band24)              grp = 3'd4;
    else if (chan <= 8'd43)  grp = 3'd0;
    else if (chan <= 8'd70)  grp = 3'd1;
    else if (chan <= 8'd124) grp = 3'd2;
    else                     grp = 3'd3;
    att = mimo ? IW'($signed(att_tab[grp*PW +: PW])) : '0;
    if (rate_sel == 3'd0 && hw_rev == 2'd1)      cck = IW'(9);
    else if (rate_sel == 3'd0 && hw_rev == 2'd2) cck = IW'(5);
    else                                         cck = '0;
  end

  assign base = IW'(fac_idx) + IW'(fac_pwr) - tgt;
  assign adj  = vr + att + cck - th;

  logic                 s1_valid, s1_b24, out_b24;
  logic signed [IW-1:0] s1_base, s1_adj, s1_tgt, tot, lo, clamped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_b24   <= 1'b0;
      s1_base  <= '0;
      s1_adj   <= '0;
      s1_tgt   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_b24  <= band24;
        s1_base <= base;
        s1_adj  <= adj;
        s1_tgt  <= tgt;
      end
    end
  end

  assign tot     = s1_base + s1_adj;
  assign lo      = s1_b24 ? IW'(0) : IW'(-9);
  assign clamped = (tot < lo) ? lo : (tot > IW'(IDX_MAX)) ? IW'(IDX_MAX) : tot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_b24   <= 1'b0;
      out_idx   <= '0;
      out_pwr   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_b24 <= s1_b24;
        out_idx <= PW'(clamped);
        out_pwr <= PW'(s1_tgt);
      end
    end
  end

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  a_r9_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx <= IDX_MAX && out_idx >= (out_b24 ? 0 : -9)));
  a_r1_reg_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pwr <= 34);
  a_r2_sat_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pwr <= 40);
endmodule

// File: tb/txgain_comp_bench.sv
module txgain_comp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_MAX = 107;
  localparam logic [39:0] ATT = {8'sd3, 8'sd2, 8'sd4, 8'sd1, 8'sd5};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, mimo = 1'b0;
  logic signed [7:0] want_pwr = '0, reg_lim = '0, sat_lim = '0, fac_idx = '0, fac_pwr = '0;
  logic [2:0] rate_sel = '0;
  logic [7:0] chan = 8'd1, fac_volt = '0, cur_volt = '0;
  logic signed [9:0] fac_temp = '0, cur_temp = '0;
  logic [1:0] hw_rev = '0;
  logic out_valid;
  logic signed [7:0] out_idx, out_pwr;

  always #(CLK_PERIOD/2) clk = ~clk;

  txgain_comp #(.IDX_MAX(IDX_MAX)) u_txgain_comp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .want_pwr(want_pwr),
    .reg_lim(reg_lim), .sat_lim(sat_lim), .rate_sel(rate_sel), .mimo(mimo),
    .chan(chan), .fac_idx(fac_idx), .fac_pwr(fac_pwr), .fac_temp(fac_temp),
    .cur_temp(cur_temp), .fac_volt(fac_volt), .cur_volt(cur_volt),
    .att_tab(ATT), .hw_rev(hw_rev), .out_valid(out_valid), .out_idx(out_idx),
    .out_pwr(out_pwr));

  typedef struct packed {
    int req, want, rg, st, rate, mi, ch, fi, fp, ft, ct, fv, cv, rev;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2, 30, 34, 38, 1, 0,   6, 60, 32, 30, 30, 100, 100, 0}, // R2 OFDM low caps at 28
    '{1, 20, 30, 50, 1, 0,   6, 60, 32, 30, 30, 100, 100, 0}, // R1 desired wins
    '{1, 34, 30, 50, 1, 0,   6, 60, 32, 30, 30, 100, 100, 0}, // R1 regulatory wins
    '{1, 34, 34, 50, 1, 1,  36, 60, 32, 30, 30, 100, 100, 0}, // R1 MIMO -6, R7 group 0
    '{2, 40, 34, 50, 2, 0,  36, 60, 32, 30, 30, 100, 100, 0}, // R2 48 Mb/s
    '{2, 40, 34, 50, 3, 0,  36, 60, 32, 30, 30, 100, 100, 0}, // R2 54 Mb/s
    '{2, 40, 34, 50, 4, 0,  36, 60, 32, 30, 30, 100, 100, 0}, // R2 60 Mb/s
    '{2, 40, 34, 40, 4, 1,  36, 60, 32, 30, 30, 100, 100, 0}, // R2 no MIMO cut on saturation
    '{3, 30, 40, 10, 1, 0,   6, 60, 32, 30, 30, 100, 100, 0}, // R3 both defaults
    '{3, 30, -1, 51, 2, 0,   6, 60, 32, 30, 30, 100, 100, 0}, // R3 negative reg, high sat
    '{4, 10, 34, 50, 1, 0,   6, 50, 20, 30, 30, 100, 100, 0}, // R4 power delta +10
    '{5, 20, 34, 50, 1, 0,   6, 60, 32, 30, 40, 100, 100, 0}, // R5 2.4 GHz hotter
    '{5, 20, 34, 50, 1, 0,  40, 60, 32, 30, 40, 100, 100, 0}, // R5 low 5 GHz hotter
    '{5, 20, 34, 50, 1, 0, 100, 60, 32, 30, 20, 100, 100, 0}, // R5 high 5 GHz colder
    '{6, 20, 34, 50, 1, 0,   6, 60, 32, 30, 30, 100,  86, 0}, // R6 rise 2
    '{6, 20, 34, 50, 1, 0,   6, 60, 32, 30, 30, 100,  79, 0}, // R6 rise 3 rejected
    '{6, 20, 34, 50, 1, 0,   6, 60, 32, 30, 30, 100, 107, 0}, // R6 fall 2
    '{6, 20, 34, 50, 1, 0,   6, 60, 32, 30, 30, 100, 111, 0}, // R6 fall 3 rejected
    '{7, 20, 34, 50, 1, 1,  60, 60, 32, 30, 30, 100, 100, 0}, // R7 group 1
    '{7, 20, 34, 50, 1, 1, 120, 60, 32, 30, 30, 100, 100, 0}, // R7 group 2
    '{7, 20, 34, 50, 1, 1, 150, 60, 32, 30, 30, 100, 100, 0}, // R7 group 3
    '{8, 20, 34, 50, 0, 0,   1, 60, 32, 30, 30, 100, 100, 1}, // R8 rev 1
    '{8, 20, 34, 50, 0, 1,  11, 60, 32, 30, 30, 100, 100, 2}, // R8 rev 2, R7 group 4
    '{8, 20, 34, 50, 0, 0,   1, 60, 32, 30, 30, 100, 100, 3}  // R8 rev 3 no offset
  };

  int n_run = 0, n_fail = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pwr(input vec_t v);
    int rg, st, bo, t;
    rg = (v.rg < 0 || v.rg > 34) ? 34 : v.rg;
    st = (v.st < 20 || v.st > 50) ? 38 : v.st;
    bo = (v.rate == 2) ? 15 : (v.rate == 3) ? 17 : (v.rate == 4) ? 20 : 10;
    rg = rg - (v.mi != 0 ? 6 : 0);
    t = (v.want < rg) ? v.want : rg;
    return (t < st - bo) ? t : st - bo;
  endfunction

  function automatic int exp_idx(input vec_t v);
    int t, th, vr, g, att, cck, idx, lo;
    logic [7:0] b;
    bit b24;
    t = exp_pwr(v);
    b24 = (v.ch <= 20);
    if (b24) th = (2 * (v.ct - v.ft)) / 7;
    else if (v.ch <= 43) th = (2 * (v.ct - v.ft)) / 9;
    else th = (2 * (v.ct - v.ft)) / 8;
    if (v.cv < v.fv) vr = (v.fv - v.cv) / 7;
    else if (v.cv > v.fv) vr = -((2 * (v.cv - v.fv)) / 7);
    else vr = 0;
    if (vr > 2 || vr < -2) vr = 0;
    g = b24 ? 4 : (v.ch <= 43) ? 0 : (v.ch <= 70) ? 1 : (v.ch <= 124) ? 2 : 3;
    b = ATT[g*8 +: 8];
    att = (v.mi != 0) ? int'($signed(b)) : 0;
    cck = (v.rate == 0) ? ((v.rev == 1) ? 9 : (v.rev == 2) ? 5 : 0) : 0;
    idx = v.fi + v.fp - t - th + vr + att + cck;
    lo = b24 ? 0 : -9;
    if (idx < lo) idx = lo;
    if (idx > IDX_MAX) idx = IDX_MAX;
    return idx;
  endfunction

  task automatic load(input vec_t v);
    want_pwr = 8'(v.want); reg_lim = 8'(v.rg); sat_lim = 8'(v.st);
    rate_sel = 3'(v.rate); mimo = (v.mi != 0); chan = 8'(v.ch);
    fac_idx = 8'(v.fi); fac_pwr = 8'(v.fp); fac_temp = 10'(v.ft);
    cur_temp = 10'(v.ct); fac_volt = 8'(v.fv); cur_volt = 8'(v.cv);
    hw_rev = 2'(v.rev);
  endtask

  task automatic run_one(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk); load(v); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check("R10 valid after two cycles", int'(out_valid), 0);
    @(negedge clk);
    check("R10 valid", int'(out_valid), 1);
    check({tag, " index"}, int'(out_idx), exp_idx(v));
    check({tag, " power"}, int'(out_pwr), exp_pwr(v));
    @(negedge clk);
    check("R10 single pulse", int'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vec_t a, b;
    repeat (3) @(negedge clk);
    check("R11 reset valid", int'(out_valid), 0);
    check("R11 reset idx", int'(out_idx), 0);
    check("R11 reset pwr", int'(out_pwr), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_one(VEC[i]);

    // R9 clamp corners
    a = '{9, 20, 34, 50, 1, 0, 100, -20, 20, 30, 30, 100, 100, 0};
    run_one(a);
    check("R9 5 GHz floor", int'(out_idx), -9);
    a = '{9, 20, 34, 50, 1, 0, 6, -20, 20, 30, 30, 100, 100, 0};
    run_one(a);
    check("R9 2.4 GHz floor", int'(out_idx), 0);
    a = '{9, 20, 34, 50, 1, 0, 6, 120, 32, 30, 30, 100, 100, 0};
    run_one(a);
    check("R9 ceiling", int'(out_idx), IDX_MAX);

    // R10 back-to-back requests
    a = VEC[3]; b = VEC[21];
    @(negedge clk); load(a); in_valid = 1'b1;
    @(negedge clk); load(b);
    @(negedge clk); in_valid = 1'b0;
    check("R10 first of pair", int'(out_idx), exp_idx(a));
    check("R10 first valid", int'(out_valid), 1);
    @(negedge clk);
    check("R10 second of pair", int'(out_idx), exp_idx(b));
    check("R10 second valid", int'(out_valid), 1);
    @(negedge clk);
    check("R10 pair ends", int'(out_valid), 0);

    // R11 reset mid-flight
    @(negedge clk); load(a); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R11 flush valid", int'(out_valid), 0);
    check("R11 flush idx", int'(out_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 no late result", int'(out_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule